// File: doc/BRIEF.md
# Gated Timer/Counter with Selectable Count Width

This block is a single timer/counter channel built around two count bytes (a low byte and a high byte) and a small control byte. As a timer it advances once per machine cycle, where one machine cycle spans twelve clocks of the oscillator that drives the block. As a counter it advances once for every high-to-low transition it sees on an external count pin. A gate option makes a run-enabled channel depend on the level of a second external pin, which lets external hardware measure pulse widths.

Three count layouts are provided. The first is a 13-bit counter made of the five low bits of the low byte under the full high byte. The second is a full 16-bit counter. The third is an 8-bit counter whose low byte is refilled from the high byte each time it wraps. Every wrap of the active layout sets a sticky overflow flag, which stays set until software clears it with a control write. For example, a reload value of 06h gives one overflow every 250 machine cycles, which is 250 µs at 12 MHz. Toggling a pin on each overflow then produces a 2 kHz square wave.

Software reaches the block through a one-cycle write strobe with a two-bit register select. The count bytes and the flag are visible on output ports at all times.

Top module: `gated_tmr`

## Requirements
- R1: After a synchronous reset, both count bytes read 00h, the overflow flag is 0, and the channel is stopped in layout 0 as a timer with the gate option off.
- R2: The prescaler starts at reset, and its first machine-cycle tick falls 12 clocks later, then every 12 clocks. The count can only change on a tick (or by a write). In timer mode an enabled channel advances by exactly one per tick, so 120 consecutive clocks give 10 increments.
- R3: The channel is enabled only when the run bit is 1 and either the gate bit is 0 or gate_pin is high. While it is disabled, both count bytes hold.
- R4: Layout 0 (mode field 0) counts in the five low bits of the low byte and carries into the high byte. Bits 7:5 of the low byte are never changed by counting. Stepping from high byte FFh with low bits 11111b wraps both parts to zero and signals an overflow.
- R5: Layout 1 (mode field 1) counts {high, low} as one 16-bit value and wraps from FFFFh to 0000h with an overflow.
- R6: Layout 2 (mode field 2) counts in the low byte only. A step from FFh loads the low byte with the high byte and signals an overflow, and the high byte is left unchanged. With the high byte at 06h, overflows come every 250 ticks (3000 clocks).
- R7: With mode field 3 the count bytes hold even when the channel is enabled.
- R8: In counter mode, cnt_pin is sampled on every tick. A sample of 1 followed by a sample of 0 on the next tick adds one step, and that step is applied on the tick after the 0 sample. A low pulse that falls between two samples is not seen.
- R9: Each overflow sets ovf_flag. The flag stays 1 until a control write carries 0 in bit 5. A control write with bit 5 at 1 leaves the flag as it is. If an overflow and a clearing write fall in the same cycle, the set wins.
- R10: A write uses wr_sel 0 for control, 1 for the low byte and 2 for the high byte; wr_sel 3 is ignored. The control byte layout is mode in bits 1:0, counter select in bit 2, gate in bit 3, run in bit 4 and flag-keep in bit 5. Any write suppresses the count step of its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin | input | 1 | External count source used in counter mode |
| gate_pin | input | 1 | External level that enables counting when the gate option is on |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 low byte, 2 high byte, 3 none |
| wr_data | input | BW (8) | Write data |
| cnt_lo | output | BW (8) | Low count byte |
| cnt_hi | output | BW (8) | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The checker runs on every cycle and checks the following rules:
- the count bytes hold while the channel is disabled or set to mode 3, and they only move on a machine-cycle tick;
- a low-byte write lands exactly;
- a layout-2 wrap reloads from the high byte;
- the flag rises after every overflow and does not fall without a clearing control write.

The bench scenarios cover what needs counting over many cycles:
- the exact rate of ten steps per 120 clocks;
- the 3000-clock overflow period with reload 06h;
- the state left after wraps in layouts 0 and 1;
- the number of pin edges that counter mode turns into steps.

The bench also compares a behavioural model against every clock throughout.

// File: rtl/gated_tmr_pkg.sv
package gated_tmr_pkg;

    typedef enum logic [1:0] {
        LAYOUT_13  = 2'd0,
        LAYOUT_16  = 2'd1,
        LAYOUT_8RL = 2'd2,
        LAYOUT_OFF = 2'd3
    } layout_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } wsel_t;

    typedef struct packed {
        logic    run;
        logic    gate;
        logic    ext;
        layout_t layout;
    } ctrl_t;

    localparam int CTRL_KEEP_BIT = 5;

    function automatic ctrl_t decode_ctrl(input logic [7:0] d);
        ctrl_t c;
        c.layout = layout_t'(d[1:0]);
        c.ext    = d[2];
        c.gate   = d[3];
        c.run    = d[4];
        return c;
    endfunction

    function automatic logic chan_enabled(input ctrl_t c, input logic gpin);
        return c.run && (!c.gate || gpin);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + CW'(1);
    end
endmodule

// File: rtl/tmr_edge_sample.sv
module tmr_edge_sample (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic edge_pend
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q    <= 1'b0;
            edge_pend <= 1'b0;
        end else if (tick) begin
            edge_pend <= last_q && !pin;
            last_q    <= pin;
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import gated_tmr_pkg::*;
#(
    parameter int BW = 8,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  layout_t       layout,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [BW-1:0] ld_val,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          wrap
);
    localparam int DW = 2 * BW;

    logic [BW-1:0] nxt_lo, nxt_hi;
    logic [DW-1:0] wide_sum;
    logic [PW-1:0] pre_sum;

    always_comb begin
        nxt_lo   = lo;
        nxt_hi   = hi;
        wrap     = 1'b0;
        wide_sum = {hi, lo} + DW'(1);
        pre_sum  = lo[PW-1:0] + PW'(1);
        unique case (layout)
            LAYOUT_13: begin
                nxt_lo[PW-1:0] = pre_sum;
                if (&lo[PW-1:0]) begin
                    nxt_hi = hi + BW'(1);
                    wrap   = &hi;
                end
            end
            LAYOUT_16: begin
                {nxt_hi, nxt_lo} = wide_sum;
                wrap = &{hi, lo};
            end
            LAYOUT_8RL: begin
                if (&lo) begin
                    nxt_lo = hi;
                    wrap   = 1'b1;
                end else begin
                    nxt_lo = lo + BW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) lo <= ld_val;
            if (ld_hi) hi <= ld_val;
        end else if (step) begin
            lo <= nxt_lo;
            hi <= nxt_hi;
        end
    end
endmodule

// File: rtl/gated_tmr.sv
module gated_tmr
    import gated_tmr_pkg::*;
#(
    parameter int BW  = 8,
    parameter int PW  = 5,
    parameter int DIV = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_pin,
    input  logic          gate_pin,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] cnt_lo,
    output logic [BW-1:0] cnt_hi,
    output logic          ovf_flag
);
    ctrl_t ctrl_q;
    logic  tick, edge_pend, enabled, src_ok, step, wrap, ovf_evt;
    logic  wr_ctrl, flag_clr;

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    tmr_edge_sample u_edge (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pin      (cnt_pin),
        .edge_pend(edge_pend)
    );

    assign wr_ctrl  = wr_en && (wsel_t'(wr_sel) == SEL_CTRL);
    assign flag_clr = wr_ctrl && !wr_data[CTRL_KEEP_BIT];
    assign enabled  = chan_enabled(ctrl_q, gate_pin);
    assign src_ok   = ctrl_q.ext ? edge_pend : 1'b1;
    assign step     = tick && enabled && src_ok && !wr_en;
    assign ovf_evt  = step && wrap;

    tmr_count_core #(.BW(BW), .PW(PW)) u_core (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .layout(ctrl_q.layout),
        .ld_lo (wr_en && (wsel_t'(wr_sel) == SEL_LO)),
        .ld_hi (wr_en && (wsel_t'(wr_sel) == SEL_HI)),
        .ld_val(wr_data),
        .lo    (cnt_lo),
        .hi    (cnt_hi),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= decode_ctrl(8'(wr_data));
    end

    always_ff @(posedge clk) begin
        if (rst)           ovf_flag <= 1'b0;
        else if (ovf_evt)  ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/gated_tmr_chk.sv
module gated_tmr_chk #(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          step,
    input logic          run,
    input logic          gate,
    input logic          gate_pin,
    input logic [1:0]    layout,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic [BW-1:0] wr_data,
    input logic [BW-1:0] lo,
    input logic [BW-1:0] hi,
    input logic          ovf_evt,
    input logic          flag
);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((!run || (gate && !gate_pin)) && !wr_en) |=> ($stable(lo) && $stable(hi)));

    assert_off_layout_R7: assert property (@(posedge clk) disable iff (rst)
        ((layout == 2'd3) && !wr_en) |=> ($stable(lo) && $stable(hi)));

    assert_tick_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> ($stable(lo) && $stable(hi)));

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (step && (layout == 2'd2) && (&lo)) |=> (lo == $past(hi) && $stable(hi)));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && wr_sel == 2'd0 && !wr_data[5])) |=> flag);

    assert_load_lo_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> (lo == $past(wr_data)));
endmodule

bind gated_tmr gated_tmr_chk #(.BW(BW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .step    (step),
    .run     (ctrl_q.run),
    .gate    (ctrl_q.gate),
    .gate_pin(gate_pin),
    .layout  (ctrl_q.layout),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lo      (cnt_lo),
    .hi      (cnt_hi),
    .ovf_evt (ovf_evt),
    .flag    (ovf_flag)
);

// File: tb/gated_tmr_tb.sv
module gated_tmr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_pin = 1'b0;
    logic       gate_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference state
    int m_lo, m_hi, m_flag, m_ph, m_prev, m_pend, m_mode, m_ext, m_gate, m_run;

    always #4 clk = ~clk;

    gated_tmr u_dut (
        .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit tk, en, stp, ovf;
        int low5, v;
        cyc++;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_flag = 0; m_ph = 0; m_prev = 0; m_pend = 0;
            m_mode = 0; m_ext = 0; m_gate = 0; m_run = 0;
        end else begin
            tk   = (m_ph == 11);
            m_ph = tk ? 0 : m_ph + 1;
            en   = (m_run != 0) && (m_gate == 0 || gate_pin);
            stp  = tk && en && (m_ext == 0 || m_pend != 0) && !wr_en;
            if (tk) begin
                m_pend = (m_prev != 0 && !cnt_pin) ? 1 : 0;
                m_prev = cnt_pin;
            end
            ovf = 0;
            if (stp) begin
                if (m_mode == 0) begin
                    low5 = m_lo % 32;
                    if (low5 == 31) begin
                        m_lo = m_lo - 31;
                        if (m_hi == 255) begin m_hi = 0; ovf = 1; end
                        else m_hi = m_hi + 1;
                    end else m_lo = m_lo + 1;
                end else if (m_mode == 1) begin
                    v = m_hi * 256 + m_lo + 1;
                    if (v == 65536) begin v = 0; ovf = 1; end
                    m_hi = v / 256; m_lo = v % 256;
                end else if (m_mode == 2) begin
                    if (m_lo == 255) begin m_lo = m_hi; ovf = 1; end
                    else m_lo = m_lo + 1;
                end
            end
            if (ovf) m_flag = 1;
            if (wr_en) begin
                if (wr_sel == 2'd0) begin
                    m_mode = wr_data % 4;
                    m_ext  = (wr_data / 4) % 2;
                    m_gate = (wr_data / 8) % 2;
                    m_run  = (wr_data / 16) % 2;
                    if (!ovf && wr_data[5] == 1'b0) m_flag = 0;
                end else if (wr_sel == 2'd1) m_lo = wr_data;
                else if (wr_sel == 2'd2) m_hi = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({tag, " lo"}, cnt_lo, m_lo);
            check({tag, " hi"}, cnt_hi, m_hi);
            check({tag, " flag"}, ovf_flag, m_flag);
        end
    end

    function automatic logic [7:0] cfg(input int mode, input bit ext, input bit gate,
                                       input bit run, input bit keep);
        return 8'(mode) | (ext ? 8'h04 : 8'h00) | (gate ? 8'h08 : 8'h00) |
               (run ? 8'h10 : 8'h00) | (keep ? 8'h20 : 8'h00);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_flag(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (ovf_flag) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        int t0, t1, base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        check("R1 lo", cnt_lo, 0);
        check("R1 hi", cnt_hi, 0);
        check("R1 flag", ovf_flag, 0);

        // R2: ten steps per 120 clocks in timer mode, layout 16
        tag = "R2";
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, cfg(1, 0, 0, 1, 0));
        base = cnt_lo;
        repeat (120) @(negedge clk);
        check("R2 rate", cnt_lo - base, 10);

        // R3: run bit cleared holds the count
        tag = "R3";
        wr(2'd0, cfg(1, 0, 0, 0, 0));
        base = cnt_lo;
        repeat (100) @(negedge clk);
        check("R3 run off hold", cnt_lo, base);
        // R3: gate on with pin low holds; pin high counts
        wr(2'd0, cfg(1, 0, 1, 1, 0));
        base = cnt_lo;
        repeat (100) @(negedge clk);
        check("R3 gate low hold", cnt_lo, base);
        gate_pin = 1'b1;
        repeat (120) @(negedge clk);
        check("R3 gate high count", cnt_lo - base, 10);
        gate_pin = 1'b0;

        // R5: 16-bit wrap
        tag = "R5";
        wr(2'd0, cfg(1, 0, 0, 0, 0));
        wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
        wr(2'd0, cfg(1, 0, 0, 1, 0));
        wait_flag(200);
        check("R5 flag", ovf_flag, 1);
        check("R5 lo", cnt_lo, 8'h00);
        check("R5 hi", cnt_hi, 8'h00);

        // R9: keep bit preserves flag, clearing write drops it
        tag = "R9";
        wr(2'd0, cfg(1, 0, 0, 0, 1));
        check("R9 keep", ovf_flag, 1);
        wr(2'd0, cfg(1, 0, 0, 0, 0));
        check("R9 clear", ovf_flag, 0);

        // R4: 13-bit layout, upper bits of low byte untouched
        tag = "R4";
        wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
        wr(2'd0, cfg(0, 0, 0, 1, 0));
        wait_flag(200);
        check("R4 flag", ovf_flag, 1);
        check("R4 lo", cnt_lo, 8'hE0);
        check("R4 hi", cnt_hi, 8'h00);

        // R6: reload from high byte
        tag = "R6";
        wr(2'd0, cfg(2, 0, 0, 0, 0));
        wr(2'd1, 8'hFE); wr(2'd2, 8'h80);
        wr(2'd0, cfg(2, 0, 0, 1, 0));
        wait_flag(200);
        check("R6 flag", ovf_flag, 1);
        check("R6 lo", cnt_lo, 8'h80);
        check("R6 hi", cnt_hi, 8'h80);
        // R6: reload 06h gives 3000-clock overflow period
        wr(2'd0, cfg(2, 0, 0, 0, 0));
        wr(2'd1, 8'h06); wr(2'd2, 8'h06);
        wr(2'd0, cfg(2, 0, 0, 1, 0));
        wait_flag(4000);
        t0 = cyc;
        wr(2'd0, cfg(2, 0, 0, 1, 0));
        wait_flag(4000);
        t1 = cyc;
        check("R6 period", t1 - t0, 3000);

        // R7: mode 3 holds
        tag = "R7";
        wr(2'd0, cfg(3, 0, 0, 1, 0));
        base = cnt_lo;
        repeat (100) @(negedge clk);
        check("R7 hold", cnt_lo, base);

        // R10: select 3 is ignored, direct loads land
        tag = "R10";
        wr(2'd0, cfg(1, 0, 0, 0, 0));
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        wr(2'd3, 8'h55);
        check("R10 lo", cnt_lo, 8'h12);
        check("R10 hi", cnt_hi, 8'h34);
        repeat (30) @(negedge clk);
        check("R10 ctrl unchanged", cnt_lo, 8'h12);

        // R8: counter mode counts falling edges of cnt_pin
        tag = "R8";
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, cfg(1, 1, 0, 1, 0));
        repeat (40) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            cnt_pin = 1'b1;
            repeat (30) @(negedge clk);
            cnt_pin = 1'b0;
            repeat (30) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        check("R8 edges", cnt_lo, 10);
        // short low pulses: outcome follows the sampling model
        for (int k = 0; k < 8; k++) begin
            cnt_pin = 1'b1;
            repeat (7 + k) @(negedge clk);
            cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        cnt_pin = 1'b0;
        repeat (40) @(negedge clk);

        finish_run();
    end
endmodule